// File: doc/BRIEF.md
# Battery Protection Fault Monitor

The block qualifies four battery-protection faults: cell overvoltage, cell undervoltage, overcurrent in discharge and short circuit in discharge. Cell voltages arrive as 14-bit ADC codes, each marked by a one-cycle valid strobe. The current channel is a sense-resistor magnitude in millivolts that the block compares on every cycle. A raw condition becomes a fault only after it has held, without a break, for a delay that the host selects from a coded table. The delay is counted in microsecond ticks for the short-circuit channel and in millisecond ticks for the other three.

Qualified faults set sticky bits in an 8-bit status byte. The host clears a bit by writing 1 to it. A summary flag is high while any fault bit is set. The host programs the block through a small write-only register port. The voltage trip levels are each built from an 8-bit register placed between fixed upper and lower bits. A range bit selects the higher of two current-threshold tables. A bypass bit removes every qualification delay, for fast production tests.

Top module: `prot_fault_mon`

## Requirements
- R1: After a synchronous reset, `status_o` is 0x00 and `fault_o` is 0. The over-trip register resets to 0xAC and the under-trip register to 0x97. Address 1 resets to 0, so the ADC-enable bit is off.
- R2: Fault bits sit at fixed positions in `status_o`: bit 0 overcurrent, bit 1 short circuit, bit 2 overvoltage, bit 3 undervoltage; bits 7:4 read 0. A set bit stays 1 until the host writes 1 to that position at address 0. A written 0 changes nothing, and the host cannot set a bit. `fault_o` is 1 exactly when any of bits 3:0 is 1.
- R3: When a qualified fault and a host clear of the same bit fall in the same cycle, the bit stays set.
- R4: The over-trip level is {2'b10, reg5[7:0], 4'b1000}. A valid cell code at or above this level raises the overvoltage condition.
- R5: The under-trip level is {2'b01, reg6[7:0], 4'b0000}. A valid cell code at or below this level raises the undervoltage condition. The condition keeps its value until the next valid sample.
- R6: Overvoltage delay code reg4[1:0] = 0..3 selects 1, 2, 4 or 8 seconds, where one second is `SEC_MS` millisecond ticks.
- R7: Undervoltage delay code reg4[3:2] = 0..3 selects 1, 4, 8 or 16 seconds.
- R8: Overcurrent delay code reg2[2:0] = 0..7 selects 8, 20, 40, 80, 160, 320, 640 or 1280 millisecond ticks.
- R9: Short-circuit delay code reg2[4:3] = 0..3 selects 70, 100, 200 or 400 microsecond ticks.
- R10: The overcurrent threshold code is reg3[3:0]. The condition is sense >= the table value. With range bit reg1[2]=0 the table runs 8,11,14,17,19,22,25,28,31,33,36,39,42,44,47,50 mV. With reg1[2]=1 it runs 17,22,28,33,39,44,50,56,61,67,72,78,83,89,94,100 mV.
- R11: The short-circuit threshold code is reg3[6:4]. With range 0 the table is 22,33,44,56,67,78,89,100 mV. With range 1 it is 44,67,89,111,133,155,178,200 mV.
- R12: If a condition drops before its count completes, the count restarts from zero. The condition is registered one cycle after the input, and a fault with an N-tick delay sets its status bit one cycle after the N-th tick that follows.
- R13: With bypass bit reg1[1]=1, a condition sets its status bit on the clock edge after the condition is registered.
- R14: While ADC-enable reg1[0] is 0, no overvoltage is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_vld | input | 1 | Cell sample strobe |
| cell_code | input | 14 | Cell voltage ADC code |
| sense_mv | input | SENSE_W | Sense-resistor voltage magnitude, mV |
| us_tick | input | 1 | Microsecond tick strobe |
| ms_tick | input | 1 | Millisecond tick strobe |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| status_o | output | 8 | Sticky fault status byte |
| fault_o | output | 1 | Any fault latched |

## Verification
The assertions take for granted that the tick strobes are one cycle wide and that the configuration stays fixed while a delay count is running. They also assume that the sense input is held steady for at least a cycle. The stimulus writes the configuration only while every condition is inactive. It drives the ticks high on every cycle, so each delay equals its tick count in cycles. It moves a condition only on a step boundary, and it removes every condition before it clears the status byte.

// File: rtl/prot_pkg.sv
`timescale 1ns/1ps
package prot_pkg;
  localparam int CELL_W = 14;
  localparam int NFLT   = 4;

  typedef enum logic [1:0] {FLT_OCD = 2'd0, FLT_SCD = 2'd1, FLT_OV = 2'd2, FLT_UV = 2'd3} flt_e;

  typedef struct packed {
    logic       adc_en;
    logic       bypass;
    logic       hi_range;
    logic [2:0] ocd_dly;
    logic [1:0] scd_dly;
    logic [3:0] ocd_thr;
    logic [2:0] scd_thr;
    logic [1:0] ov_dly;
    logic [1:0] uv_dly;
    logic [7:0] ov_mid;
    logic [7:0] uv_mid;
  } prot_cfg_t;

  function automatic logic [CELL_W-1:0] over_level(input logic [7:0] mid);
    return {2'b10, mid, 4'b1000};
  endfunction

  function automatic logic [CELL_W-1:0] under_level(input logic [7:0] mid);
    return {2'b01, mid, 4'b0000};
  endfunction

  function automatic logic [15:0] ov_secs(input logic [1:0] c);
    return 16'd1 << c;
  endfunction

  function automatic logic [15:0] uv_secs(input logic [1:0] c);
    return (c == 2'd0) ? 16'd1 : (16'd2 << c);
  endfunction

  function automatic logic [15:0] ocd_ms(input logic [2:0] c);
    return (c == 3'd0) ? 16'd8 : (16'd20 << (c - 3'd1));
  endfunction

  function automatic logic [15:0] scd_us(input logic [1:0] c);
    return (c == 2'd0) ? 16'd70 : (16'd100 << (c - 2'd1));
  endfunction

  function automatic logic [7:0] ocd_mv(input logic hi, input logic [3:0] c);
    logic [7:0] v;
    case (c)
      4'h0: v = hi ? 8'd17  : 8'd8;
      4'h1: v = hi ? 8'd22  : 8'd11;
      4'h2: v = hi ? 8'd28  : 8'd14;
      4'h3: v = hi ? 8'd33  : 8'd17;
      4'h4: v = hi ? 8'd39  : 8'd19;
      4'h5: v = hi ? 8'd44  : 8'd22;
      4'h6: v = hi ? 8'd50  : 8'd25;
      4'h7: v = hi ? 8'd56  : 8'd28;
      4'h8: v = hi ? 8'd61  : 8'd31;
      4'h9: v = hi ? 8'd67  : 8'd33;
      4'hA: v = hi ? 8'd72  : 8'd36;
      4'hB: v = hi ? 8'd78  : 8'd39;
      4'hC: v = hi ? 8'd83  : 8'd42;
      4'hD: v = hi ? 8'd89  : 8'd44;
      4'hE: v = hi ? 8'd94  : 8'd47;
      default: v = hi ? 8'd100 : 8'd50;
    endcase
    return v;
  endfunction

  function automatic logic [7:0] scd_mv(input logic hi, input logic [2:0] c);
    logic [7:0] v;
    case (c)
      3'd0: v = hi ? 8'd44  : 8'd22;
      3'd1: v = hi ? 8'd67  : 8'd33;
      3'd2: v = hi ? 8'd89  : 8'd44;
      3'd3: v = hi ? 8'd111 : 8'd56;
      3'd4: v = hi ? 8'd133 : 8'd67;
      3'd5: v = hi ? 8'd155 : 8'd78;
      3'd6: v = hi ? 8'd178 : 8'd89;
      default: v = hi ? 8'd200 : 8'd100;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/prot_cfg_regs.sv
`timescale 1ns/1ps
module prot_cfg_regs
  import prot_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int NBITS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output prot_cfg_t         cfg_o,
  output logic [NBITS-1:0]  clr_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CDLY = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CTHR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_VDLY = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_OVM  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_UVM  = ADDR_W'(6);

  prot_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q        <= '0;
      cfg_q.ov_mid <= 8'hAC;
      cfg_q.uv_mid <= 8'h97;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: {cfg_q.hi_range, cfg_q.bypass, cfg_q.adc_en} <= wdata_i[2:0];
        A_CDLY: {cfg_q.scd_dly, cfg_q.ocd_dly} <= wdata_i[4:0];
        A_CTHR: {cfg_q.scd_thr, cfg_q.ocd_thr} <= wdata_i[6:0];
        A_VDLY: {cfg_q.uv_dly, cfg_q.ov_dly} <= wdata_i[3:0];
        A_OVM:  cfg_q.ov_mid <= wdata_i;
        A_UVM:  cfg_q.uv_mid <= wdata_i;
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
  assign clr_o = (we_i && addr_i == A_STAT) ? wdata_i[NBITS-1:0] : '0;
endmodule

// File: rtl/prot_detect.sv
`timescale 1ns/1ps
module prot_detect
  import prot_pkg::*;
#(
  parameter int SENSE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  prot_cfg_t          cfg_i,
  input  logic               cell_vld_i,
  input  logic [CELL_W-1:0]  cell_code_i,
  input  logic [SENSE_W-1:0] sense_i,
  output logic [NFLT-1:0]    hit_o
);
  logic [CELL_W-1:0] ov_lvl, uv_lvl;
  logic [7:0]        ocd_lvl, scd_lvl;
  logic              ov_q, uv_q, ocd_q, scd_q;

  always_comb begin
    ov_lvl  = over_level(cfg_i.ov_mid);
    uv_lvl  = under_level(cfg_i.uv_mid);
    ocd_lvl = ocd_mv(cfg_i.hi_range, cfg_i.ocd_thr);
    scd_lvl = scd_mv(cfg_i.hi_range, cfg_i.scd_thr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q  <= 1'b0;
      uv_q  <= 1'b0;
      ocd_q <= 1'b0;
      scd_q <= 1'b0;
    end else begin
      if (!cfg_i.adc_en)   ov_q <= 1'b0;
      else if (cell_vld_i) ov_q <= (cell_code_i >= ov_lvl);
      if (cell_vld_i)      uv_q <= (cell_code_i <= uv_lvl);
      ocd_q <= (32'(sense_i) >= 32'(ocd_lvl));
      scd_q <= (32'(sense_i) >= 32'(scd_lvl));
    end
  end

  always_comb begin
    hit_o         = '0;
    hit_o[FLT_OCD] = ocd_q;
    hit_o[FLT_SCD] = scd_q;
    hit_o[FLT_OV]  = ov_q;
    hit_o[FLT_UV]  = uv_q;
  end

  // R14: overvoltage condition is held low while the ADC is disabled
  a_r14_adc_gate: assert property (@(posedge clk) disable iff (rst)
    !cfg_i.adc_en |=> !hit_o[FLT_OV]);
endmodule

// File: rtl/prot_delay_qual.sv
`timescale 1ns/1ps
module prot_delay_qual #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit_i,
  input  logic         tick_i,
  input  logic         bypass_i,
  input  logic [W-1:0] target_i,
  output logic         qual_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !hit_i)                  cnt_q <= '0;
    else if (tick_i && cnt_q < target_i) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = hit_i && (bypass_i || cnt_q >= target_i);

  // R12: a dropped condition restarts the count
  a_r12_restart: assert property (@(posedge clk) disable iff (rst)
    !hit_i |=> cnt_q == '0);
  // R12: a counted qualification needs the condition held on the prior cycle
  a_r12_held: assert property (@(posedge clk) disable iff (rst)
    (qual_o && !bypass_i) |-> $past(hit_i));
  // R13: bypass qualifies any present condition at once
  a_r13_bypass: assert property (@(posedge clk) disable iff (rst)
    (hit_i && bypass_i) |-> qual_o);
endmodule

// File: rtl/prot_status.sv
`timescale 1ns/1ps
module prot_status #(
  parameter int NBITS = 4,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] set_i,
  input  logic [NBITS-1:0] clr_i,
  output logic [OUT_W-1:0] status_o,
  output logic             fault_o
);
  logic [NBITS-1:0] st_q, st_n;

  always_comb st_n = (st_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= '0;
      fault_o <= 1'b0;
    end else begin
      st_q    <= st_n;
      fault_o <= |st_n;
    end
  end

  assign status_o = OUT_W'(st_q);

  // R2: summary flag tracks the latched bits
  a_r2_flag: assert property (@(posedge clk) disable iff (rst)
    fault_o == (|status_o[NBITS-1:0]));

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    // R2: a set bit holds until written with 1
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
      (status_o[i] && !clr_i[i]) |=> status_o[i]);
    // R2: only a qualified fault can raise a bit
    a_r2_no_host_set: assert property (@(posedge clk) disable iff (rst)
      (!status_o[i] && !set_i[i]) |=> !status_o[i]);
    // R3: set beats a simultaneous clear
    a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> status_o[i]);
  end
endmodule

// File: rtl/prot_fault_mon.sv
`timescale 1ns/1ps
module prot_fault_mon
  import prot_pkg::*;
#(
  parameter int SENSE_W = 8,
  parameter int SEC_MS  = 1000,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cell_vld,
  input  logic [13:0]        cell_code,
  input  logic [SENSE_W-1:0] sense_mv,
  input  logic               us_tick,
  input  logic               ms_tick,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         status_o,
  output logic               fault_o
);
  localparam int MAX_T = (16 * SEC_MS > 1280) ? 16 * SEC_MS : 1280;
  localparam int CNT_W = $clog2(MAX_T + 1);

  prot_cfg_t         cfg;
  logic [NFLT-1:0]   clr, hit, qual, tick;
  logic [CNT_W-1:0]  tgt [NFLT];

  prot_cfg_regs #(.ADDR_W(ADDR_W), .NBITS(NFLT)) i_regs (
    .clk(clk), .rst(rst), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .cfg_o(cfg), .clr_o(clr)
  );

  prot_detect #(.SENSE_W(SENSE_W)) i_detect (
    .clk(clk), .rst(rst), .cfg_i(cfg), .cell_vld_i(cell_vld),
    .cell_code_i(cell_code), .sense_i(sense_mv), .hit_o(hit)
  );

  always_comb begin
    tgt[FLT_OCD] = CNT_W'(ocd_ms(cfg.ocd_dly));
    tgt[FLT_SCD] = CNT_W'(scd_us(cfg.scd_dly));
    tgt[FLT_OV]  = CNT_W'(32'(ov_secs(cfg.ov_dly)) * SEC_MS);
    tgt[FLT_UV]  = CNT_W'(32'(uv_secs(cfg.uv_dly)) * SEC_MS);
  end

  for (genvar f = 0; f < NFLT; f++) begin : g_qual
    if (f == int'(FLT_SCD)) begin : g_us
      assign tick[f] = us_tick;
    end else begin : g_ms
      assign tick[f] = ms_tick;
    end
    prot_delay_qual #(.W(CNT_W)) i_qual (
      .clk(clk), .rst(rst), .hit_i(hit[f]), .tick_i(tick[f]),
      .bypass_i(cfg.bypass), .target_i(tgt[f]), .qual_o(qual[f])
    );
  end

  prot_status #(.NBITS(NFLT), .OUT_W(8)) i_status (
    .clk(clk), .rst(rst), .set_i(qual), .clr_i(clr),
    .status_o(status_o), .fault_o(fault_o)
  );
endmodule

// File: tb/test_prot_fault_mon.sv
`timescale 1ns/1ps
module test_prot_fault_mon;
  localparam int SEC = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cell_vld = 1'b0, us_tick = 1'b0, ms_tick = 1'b0;
  logic [13:0] cell_code = 14'h2000;
  logic [7:0]  sense_mv = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  status_o;
  logic        fault_o;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] exp_q [$];
  logic [7:0] msk_q [$];
  string      tag_q [$];

  int ocd_d [8] = '{8, 20, 40, 80, 160, 320, 640, 1280};
  int scd_d [4] = '{70, 100, 200, 400};
  int ov_d  [4] = '{1, 2, 4, 8};
  int uv_d  [4] = '{1, 4, 8, 16};
  int ocd_lo [16] = '{8,11,14,17,19,22,25,28,31,33,36,39,42,44,47,50};
  int ocd_hi [16] = '{17,22,28,33,39,44,50,56,61,67,72,78,83,89,94,100};
  int scd_lo [8] = '{22,33,44,56,67,78,89,100};
  int scd_hi [8] = '{44,67,89,111,133,155,178,200};

  prot_fault_mon #(.SENSE_W(8), .SEC_MS(SEC), .ADDR_W(3)) i_prot_fault_mon (
    .clk(clk), .rst(rst), .cell_vld(cell_vld), .cell_code(cell_code),
    .sense_mv(sense_mv), .us_tick(us_tick), .ms_tick(ms_tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .status_o(status_o), .fault_o(fault_o)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 150000", cycles);
      finish_run();
    end
  end

  // monitor: compare queued expectations against the ports
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic logic [7:0] m = msk_q.pop_front();
      automatic string      t = tag_q.pop_front();
      checks++;
      if ((status_o & m) !== (e & m)) begin
        errors++;
        $display("FAIL %s: status actual %02h expected %02h (mask %02h)", t, status_o & m, e & m, m);
      end else if (m == 8'hFF && fault_o !== (|e[3:0])) begin
        errors++;
        $display("FAIL %s: fault flag actual %0b expected %0b", t, fault_o, |e[3:0]);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_st(input logic [7:0] e, input logic [7:0] m, input string t);
    exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(t);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic sample(input logic [13:0] c);
    cell_code = c; cell_vld = 1'b1;
    step();
    cell_vld = 1'b0;
  endtask

  // called just after the edge that registered the condition
  task automatic run_delay(input int n, input int b, input string t);
    repeat (n) step();
    expect_st(8'h00, 8'(1 << b), t);
    step();
    expect_st(8'(1 << b), 8'(1 << b), t);
  endtask

  task automatic clear_all(input string t);
    sense_mv = '0;
    sample(14'h2000);
    step();
    wr(3'd0, 8'h0F);
    expect_st(8'h00, 8'hFF, t);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    expect_st(8'h00, 8'hFF, "R1 reset state");
    step();
    us_tick = 1'b1; ms_tick = 1'b1;

    // R1/R4/R5 default trip levels with bypass
    wr(3'd1, 8'h03);
    sample(14'h2AC7); step(); expect_st(8'h00, 8'h04, "R1 R4 default over below");
    sample(14'h2AC8); run_delay(0, 2, "R1 R4 default over at level");
    clear_all("R2 clear after over");
    sample(14'h1971); step(); expect_st(8'h00, 8'h08, "R1 R5 default under above");
    sample(14'h1970); run_delay(0, 3, "R1 R5 default under at level");
    clear_all("R2 clear after under");

    // R14: ADC disabled blocks overvoltage
    wr(3'd1, 8'h02);
    sample(14'h3FFF); step(); step(); expect_st(8'h00, 8'h04, "R14 adc off no over");
    clear_all("R14 clear");

    // R6 / R7 voltage delay codes
    wr(3'd1, 8'h01);
    for (int c = 0; c < 4; c++) begin
      wr(3'd4, 8'(c));
      sample(14'h3FFF); run_delay(ov_d[c] * SEC, 2, $sformatf("R6 over delay code %0d", c));
      clear_all("R6 clear");
      wr(3'd4, 8'(c << 2));
      sample(14'h0000); run_delay(uv_d[c] * SEC, 3, $sformatf("R7 under delay code %0d", c));
      clear_all("R7 clear");
    end

    // R8 overcurrent delay codes (short-circuit level kept above sense)
    wr(3'd3, 8'h70);
    for (int c = 0; c < 8; c++) begin
      wr(3'd2, 8'(c));
      sense_mv = 8'd50; step();
      run_delay(ocd_d[c], 0, $sformatf("R8 overcurrent delay code %0d", c));
      clear_all("R8 clear");
    end

    // R9 short-circuit delay codes
    for (int c = 0; c < 4; c++) begin
      wr(3'd2, 8'(c << 3));
      sense_mv = 8'd255; step();
      run_delay(scd_d[c], 1, $sformatf("R9 short delay code %0d", c));
      clear_all("R9 clear");
    end

    // R12: dropout before completion restarts the count (code 0 = 8 ticks)
    wr(3'd2, 8'h00);
    sense_mv = 8'd50; step();
    repeat (6) step();
    sense_mv = 8'd0; step(); step();
    repeat (10) step();
    expect_st(8'h00, 8'hFF, "R12 dropout no fault");
    sense_mv = 8'd50; step();
    run_delay(8, 0, "R12 full count after restart");
    clear_all("R12 clear");

    // R13 bypass on the longest codes
    wr(3'd1, 8'h03);
    wr(3'd2, 8'h1F);
    wr(3'd4, 8'h0F);
    sample(14'h3FFF); run_delay(0, 2, "R13 bypass over");
    clear_all("R13 clear");
    sample(14'h0000); run_delay(0, 3, "R13 bypass under");
    clear_all("R13 clear");
    sense_mv = 8'd50; step(); run_delay(0, 0, "R13 bypass overcurrent");
    clear_all("R13 clear");
    sense_mv = 8'd255; step(); run_delay(0, 1, "R13 bypass short");
    clear_all("R13 clear");

    // R10 / R11 threshold tables in both ranges
    for (int r = 0; r < 2; r++) begin
      wr(3'd1, 8'(3 | (r << 2)));
      for (int k = 0; k < 16; k++) begin
        automatic int th = r ? ocd_hi[k] : ocd_lo[k];
        wr(3'd3, 8'(8'h70 | k));
        sense_mv = 8'(th - 1); step(); step();
        expect_st(8'h00, 8'h01, $sformatf("R10 range %0d code %0d below", r, k));
        sense_mv = 8'(th); step();
        run_delay(0, 0, $sformatf("R10 range %0d code %0d at level", r, k));
        clear_all("R10 clear");
      end
      for (int k = 0; k < 8; k++) begin
        automatic int th = r ? scd_hi[k] : scd_lo[k];
        wr(3'd3, 8'(k << 4));
        sense_mv = 8'(th - 1); step(); step();
        expect_st(8'h00, 8'h02, $sformatf("R11 range %0d code %0d below", r, k));
        sense_mv = 8'(th); step();
        run_delay(0, 1, $sformatf("R11 range %0d code %0d at level", r, k));
        clear_all("R11 clear");
      end
    end

    // R2 write-1-to-clear per bit, R3 set beats clear
    wr(3'd1, 8'h03);
    wr(3'd3, 8'h00);
    sense_mv = 8'd255; step(); step();
    expect_st(8'h03, 8'hFF, "R2 both current bits set");
    wr(3'd0, 8'h03);
    expect_st(8'h03, 8'hFF, "R3 set wins over clear");
    sense_mv = 8'd0; step(); step();
    wr(3'd0, 8'h00);
    expect_st(8'h03, 8'hFF, "R2 writing zero keeps bits");
    wr(3'd5, 8'hFF);
    expect_st(8'h03, 8'hFF, "R2 other address leaves status");
    wr(3'd0, 8'h02);
    expect_st(8'h01, 8'hFF, "R2 clear bit 1 only");
    wr(3'd0, 8'h01);
    expect_st(8'h00, 8'hFF, "R2 clear bit 0");

    // R4 / R5 programmed trip levels
    wr(3'd5, 8'h12);
    wr(3'd6, 8'hE5);
    sample(14'h2127); step(); expect_st(8'h00, 8'h04, "R4 programmed over below");
    sample(14'h2128); run_delay(0, 2, "R4 programmed over at level");
    clear_all("R4 clear");
    sample(14'h1E51); step(); expect_st(8'h00, 8'h08, "R5 programmed under above");
    sample(14'h1E50); run_delay(0, 3, "R5 programmed under at level");
    clear_all("R5 clear");

    step(); step();
    finish_run();
  end
endmodule